// File: doc/BRIEF.md
# Keyed Code-Space Remap Controller

This block is a small system-control unit on the data bus of an 8-bit microcontroller. Software writes a three-bit control byte into a staged register. None of the staged bits acts on the chip until a matching unlock byte is written to a separate write-only key register. One key value commits the RAM-mapping and vector-remap bits together. A second commits the reset-disable bit. A third commits nothing and fires a one-cycle flag-clear pulse that another block consumes.

The committed state drives a combinational decoder for code-space fetch addresses. When RAM mapping is on, a low window of code space goes to internal RAM. When vector remapping is also on, the vector-call table and the interrupt vector table are redirected to RAM copies, which sit 0xFE00 lower. The reset vector always stays in the boot vector ROM. A serial boot-loader mode input forces the low window onto RAM whatever the committed bit says. Every fetch address selects exactly one of four regions, and the block also returns the translated address.

Top module: `remap_ctl`

## Requirements
- R1: After reset all committed bits are 0. The staged control value reads back as 0x00, `rstDisable` and `flagClrPulse` are 0, fetches in 0x0040–0x083F select low ROM, and fetches at 0xFFA0 select vector ROM.
- R2: A bus write to 0x0FDE updates only the staged value, in bits 2 (vector remap), 1 (RAM map) and 0 (reset disable). A read at 0x0FDE returns the staged bits with bits 7:3 read as 0. A staged change alone does not alter the decode.
- R3: Writing 0xD4 to the key register at 0x0FDF copies the staged bits 2 and 1 into the committed vector-remap and RAM-map bits at that clock edge. The decoder uses them from the next cycle on.
- R4: Writing 0xB2 to the key register copies staged bit 0 to the `rstDisable` output, which is valid in the next cycle. The RAM-map and vector-remap bits are left as they were.
- R5: Writing 0x71 to the key register raises `flagClrPulse` for exactly the one cycle after the write.
- R6: Any other key value commits nothing. A read at 0x0FDF always returns 0x00.
- R7: When RAM map is committed, fetches from 0x0040 to 0x083F inclusive select RAM and `xlatAddr` equals the fetch address. 0x003F and 0x0840 select main ROM.
- R8: When both RAM map and vector remap are committed, fetches at 0xFFA0–0xFFBF and 0xFFCC–0xFFFD select RAM with `xlatAddr` = fetch − 0xFE00. Addresses between the two tables (0xFFC0–0xFFCB) select main ROM.
- R9: When vector remap is committed but RAM map is not, vector-table fetches select vector ROM and are not translated.
- R10: Fetches at 0xFFFE–0xFFFF always select vector ROM.
- R11: While `bootMode` is 1, fetches in 0x0040–0x083F select RAM regardless of the RAM-map bit. Vector tables still follow the committed bits.
- R12: Exactly one of `selRam`, `selLowRom`, `selVecRom`, `selRom` is high in every cycle. `xlatAddr` equals the fetch address except on a remapped vector fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Bus write strobe, sampled on the rising edge |
| busAddr | input | 16 | Bus register address, for both reads and writes |
| busWrData | input | 8 | Bus write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| fetchAddr | input | 16 | Code-space fetch address |
| bootMode | input | 1 | Serial boot-loader mode; forces the low window onto RAM |
| selRam | output | 1 | Fetch goes to internal RAM |
| selLowRom | output | 1 | Fetch in the low window goes to ROM |
| selVecRom | output | 1 | Fetch goes to the boot vector ROM |
| selRom | output | 1 | Fetch goes to main ROM |
| xlatAddr | output | 16 | Translated fetch address |
| rstDisable | output | 1 | Committed reset-disable bit |
| flagClrPulse | output | 1 | One-cycle flag-clear enable |

## Verification
The region selects, `xlatAddr` and `busRdData` are combinational, so they are due in the same cycle as the address that produces them. The bench drives inputs just after a rising edge and compares at the following falling edge. Committed bits, `rstDisable` and `flagClrPulse` change at the edge that samples the key write, so they are checked in the cycle after it. The driver queues one expected item per cycle, which keeps each expectation in the cycle it belongs to. The write cycle itself is queued as unchecked, and `flagClrPulse` is also checked as 0 in the cycle after its single high cycle.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef struct packed {
    logic stageWr;
    logic rdCtrl;
    logic keyMap;
    logic keyRst;
    logic keyFlag;
  } ctlStrobes_t;

  typedef struct packed {
    logic ram;
    logic lowRom;
    logic vecRom;
    logic rom;
  } regionSel_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0FDE,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 16'h0FDF,
  parameter logic [DATA_W-1:0] KEY_MAP   = 8'hD4,
  parameter logic [DATA_W-1:0] KEY_RST   = 8'hB2,
  parameter logic [DATA_W-1:0] KEY_FLAG  = 8'h71
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output ctlStrobes_t       strobes
);
  logic hitCtrl, hitKey, keyWr;

  always_comb begin
    hitCtrl = (busAddr == CTRL_ADDR);
    hitKey  = (busAddr == KEY_ADDR);
    keyWr   = busWr && hitKey;
    strobes.stageWr = busWr && hitCtrl;
    strobes.rdCtrl  = hitCtrl;
    strobes.keyMap  = keyWr && (busWrData == KEY_MAP);
    strobes.keyRst  = keyWr && (busWrData == KEY_RST);
    strobes.keyFlag = keyWr && (busWrData == KEY_FLAG);
  end
endmodule

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 3,
  parameter int VEC_BIT = 2,
  parameter int MAP_BIT = 1,
  parameter int RST_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [CTRL_W-1:0] wrBits,
  output logic [DATA_W-1:0] rdData,
  output logic              mapOn,
  output logic              vecOn,
  output logic              rstDisable,
  output logic              flagClrPulse
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [CTRL_W-1:0] staged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      staged       <= '0;
      mapOn        <= 1'b0;
      vecOn        <= 1'b0;
      rstDisable   <= 1'b0;
      flagClrPulse <= 1'b0;
    end else begin
      if (strobes.stageWr) staged <= wrBits;
      if (strobes.keyMap) begin
        mapOn <= staged[MAP_BIT];
        vecOn <= staged[VEC_BIT];
      end
      if (strobes.keyRst) rstDisable <= staged[RST_BIT];
      flagClrPulse <= strobes.keyFlag;
    end
  end

  always_comb begin
    rdData = strobes.rdCtrl ? {{PAD_W{1'b0}}, staged} : '0;
  end
endmodule

// File: rtl/remap_dec.sv
module remap_dec
  import remap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_LO   = 16'h0040,
  parameter logic [ADDR_W-1:0] WIN_HI   = 16'h083F,
  parameter logic [ADDR_W-1:0] VCALL_LO = 16'hFFA0,
  parameter logic [ADDR_W-1:0] VCALL_HI = 16'hFFBF,
  parameter logic [ADDR_W-1:0] IRQ_LO   = 16'hFFCC,
  parameter logic [ADDR_W-1:0] IRQ_HI   = 16'hFFFD,
  parameter logic [ADDR_W-1:0] RSTV_LO  = 16'hFFFE,
  parameter logic [ADDR_W-1:0] VEC_OFFSET = 16'hFE00
) (
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              bootMode,
  input  logic              mapOn,
  input  logic              vecOn,
  output regionSel_t        sel,
  output logic [ADDR_W-1:0] xlatAddr
);
  logic inWin, inVcall, inIrq, inRstVec, vecLive;

  always_comb begin
    inWin    = (fetchAddr >= WIN_LO) && (fetchAddr <= WIN_HI);
    inVcall  = (fetchAddr >= VCALL_LO) && (fetchAddr <= VCALL_HI);
    inIrq    = (fetchAddr >= IRQ_LO) && (fetchAddr <= IRQ_HI);
    inRstVec = (fetchAddr >= RSTV_LO);
    vecLive  = vecOn && mapOn;
    sel      = '0;
    xlatAddr = fetchAddr;
    if (inRstVec) begin
      sel.vecRom = 1'b1;
    end else if (inVcall || inIrq) begin
      if (vecLive) begin
        sel.ram  = 1'b1;
        xlatAddr = fetchAddr - VEC_OFFSET;
      end else begin
        sel.vecRom = 1'b1;
      end
    end else if (inWin) begin
      if (mapOn || bootMode) sel.ram = 1'b1;
      else                   sel.lowRom = 1'b1;
    end else begin
      sel.rom = 1'b1;
    end
  end
endmodule

// File: rtl/remap_ctl.sv
module remap_ctl
  import remap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0FDE,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 16'h0FDF,
  parameter logic [DATA_W-1:0] KEY_MAP   = 8'hD4,
  parameter logic [DATA_W-1:0] KEY_RST   = 8'hB2,
  parameter logic [DATA_W-1:0] KEY_FLAG  = 8'h71,
  parameter logic [ADDR_W-1:0] WIN_LO    = 16'h0040,
  parameter logic [ADDR_W-1:0] WIN_HI    = 16'h083F,
  parameter logic [ADDR_W-1:0] RSTV_LO   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              bootMode,
  output logic              selRam,
  output logic              selLowRom,
  output logic              selVecRom,
  output logic              selRom,
  output logic [ADDR_W-1:0] xlatAddr,
  output logic              rstDisable,
  output logic              flagClrPulse
);
  localparam int CTRL_W = 3;

  ctlStrobes_t strobes;
  regionSel_t  sel;
  logic        mapOn, vecOn;

  remap_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR),
    .KEY_MAP(KEY_MAP), .KEY_RST(KEY_RST), .KEY_FLAG(KEY_FLAG)
  ) u_ctrl (
    .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData), .strobes(strobes)
  );

  remap_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrBits(busWrData[CTRL_W-1:0]),
    .rdData(busRdData), .mapOn(mapOn), .vecOn(vecOn),
    .rstDisable(rstDisable), .flagClrPulse(flagClrPulse)
  );

  remap_dec #(
    .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .RSTV_LO(RSTV_LO)
  ) u_dec (
    .fetchAddr(fetchAddr), .bootMode(bootMode), .mapOn(mapOn), .vecOn(vecOn),
    .sel(sel), .xlatAddr(xlatAddr)
  );

  assign selRam    = sel.ram;
  assign selLowRom = sel.lowRom;
  assign selVecRom = sel.vecRom;
  assign selRom    = sel.rom;
endmodule

// File: rtl/remap_ctl_chk.sv
module remap_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0FDE,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 16'h0FDF,
  parameter logic [DATA_W-1:0] KEY_MAP   = 8'hD4,
  parameter logic [DATA_W-1:0] KEY_FLAG  = 8'h71,
  parameter logic [ADDR_W-1:0] WIN_LO    = 16'h0040,
  parameter logic [ADDR_W-1:0] WIN_HI    = 16'h083F,
  parameter logic [ADDR_W-1:0] RSTV_LO   = 16'hFFFE
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              bootMode,
  input logic              selRam,
  input logic              selLowRom,
  input logic              selVecRom,
  input logic              selRom,
  input logic              flagClrPulse
);
  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rstN)
    $countones({selRam, selLowRom, selVecRom, selRom}) == 1); // R12

  AST_RESET_VECTOR_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (fetchAddr >= RSTV_LO) |-> selVecRom); // R10

  AST_BOOT_WINDOW_RAM: assert property (@(posedge clk) disable iff (!rstN)
    (bootMode && fetchAddr >= WIN_LO && fetchAddr <= WIN_HI) |-> selRam); // R11

  AST_FLAG_FROM_KEY: assert property (@(posedge clk) disable iff (!rstN)
    flagClrPulse |-> $past(busWr && busAddr == KEY_ADDR && busWrData == KEY_FLAG)); // R5

  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == KEY_ADDR) |-> (busRdData == '0)); // R6

  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == CTRL_ADDR) |-> (busRdData[DATA_W-1:3] == '0)); // R2

  AST_RAM_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busWr && busAddr == KEY_ADDR && busWrData == KEY_MAP)
      && $stable(fetchAddr) && $stable(bootMode)) |-> $stable(selRam)); // R3
endmodule

bind remap_ctl remap_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR),
  .KEY_MAP(KEY_MAP), .KEY_FLAG(KEY_FLAG), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
  .RSTV_LO(RSTV_LO)
) u_chk (.*);

// File: tb/sim_remap_ctl.sv
`timescale 1ns/1ps
module sim_remap_ctl;
  localparam logic [15:0] CTRL = 16'h0FDE;
  localparam logic [15:0] KEY  = 16'h0FDF;
  localparam logic [3:0] S_RAM = 4'b1000, S_LOW = 4'b0100, S_VEC = 4'b0010, S_ROM = 4'b0001;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 1'b0, bootMode = 1'b0;
  logic [15:0] busAddr = '0, fetchAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic selRam, selLowRom, selVecRom, selRom, rstDisable, flagClrPulse;
  logic [15:0] xlatAddr;

  int nChk = 0, nBad = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          chk;
    logic [3:0]  sel;
    logic [15:0] xlat;
    logic [7:0]  rd;
    logic        rst;
    logic        flag;
    string       tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  remap_ctl u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .fetchAddr(fetchAddr), .bootMode(bootMode),
    .selRam(selRam), .selLowRom(selLowRom), .selVecRom(selVecRom), .selRom(selRom),
    .xlatAddr(xlatAddr), .rstDisable(rstDisable), .flagClrPulse(flagClrPulse)
  );

  task automatic cyc(input logic [15:0] f, input logic w, input logic [15:0] a,
                     input logic [7:0] d, input bit ck, input logic [3:0] es,
                     input logic [15:0] ex, input logic [7:0] er, input logic erst,
                     input logic efl, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    fetchAddr = f; busWr = w; busAddr = a; busWrData = d;
    it.chk = ck; it.sel = es; it.xlat = ex; it.rd = er;
    it.rst = erst; it.flag = efl; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(16'h0000, 1'b1, a, d, 1'b0, '0, '0, '0, 1'b0, 1'b0, "write");
  endtask

  task automatic chk(input logic [15:0] f, input logic [15:0] a, input logic [3:0] es,
                     input logic [15:0] ex, input logic [7:0] er, input logic erst,
                     input logic efl, input string tag);
    cyc(f, 1'b0, a, 8'h00, 1'b1, es, ex, er, erst, efl, tag);
  endtask

  // monitor: one item per cycle, compared at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [3:0] gotSel;
        it = q.pop_front();
        gotSel = {selRam, selLowRom, selVecRom, selRom};
        if (it.chk) begin
          nChk++;
          if (gotSel !== it.sel || xlatAddr !== it.xlat || busRdData !== it.rd ||
              rstDisable !== it.rst || flagClrPulse !== it.flag) begin
            nBad++;
            $display("FAIL %s: sel=%b xlat=%h rd=%h rst=%b flag=%b expected sel=%b xlat=%h rd=%h rst=%b flag=%b",
                     it.tag, gotSel, xlatAddr, busRdData, rstDisable, flagClrPulse,
                     it.sel, it.xlat, it.rd, it.rst, it.flag);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk(16'h0040, CTRL, S_LOW, 16'h0040, 8'h00, 1'b0, 1'b0, "R1 window low ROM, staged 0");
    chk(16'hFFA0, KEY,  S_VEC, 16'hFFA0, 8'h00, 1'b0, 1'b0, "R1 vector ROM");
    // R2 staging only
    wr(CTRL, 8'h07);
    chk(16'h0040, CTRL, S_LOW, 16'h0040, 8'h07, 1'b0, 1'b0, "R2 staged readback, no decode change");
    wr(CTRL, 8'hFF);
    chk(16'h0040, CTRL, S_LOW, 16'h0040, 8'h07, 1'b0, 1'b0, "R2 high bits read 0");
    // R6 wrong key
    wr(KEY, 8'h55);
    chk(16'h0040, KEY, S_LOW, 16'h0040, 8'h00, 1'b0, 1'b0, "R6 other key no effect, key reads 0");
    // R4 reset-disable key
    wr(KEY, 8'hB2);
    chk(16'h0040, CTRL, S_LOW, 16'h0040, 8'h07, 1'b1, 1'b0, "R4 rstDisable committed, map untouched");
    // R3 map key
    wr(KEY, 8'hD4);
    chk(16'h0040, CTRL, S_RAM, 16'h0040, 8'h07, 1'b1, 1'b0, "R3 map committed next cycle");
    chk(16'h083F, 16'h0, S_RAM, 16'h083F, 8'h00, 1'b1, 1'b0, "R7 window top");
    chk(16'h003F, 16'h0, S_ROM, 16'h003F, 8'h00, 1'b1, 1'b0, "R7 R12 below window");
    chk(16'h0840, 16'h0, S_ROM, 16'h0840, 8'h00, 1'b1, 1'b0, "R7 above window");
    chk(16'hFFA0, 16'h0, S_RAM, 16'h01A0, 8'h00, 1'b1, 1'b0, "R8 call table low");
    chk(16'hFFBF, 16'h0, S_RAM, 16'h01BF, 8'h00, 1'b1, 1'b0, "R8 call table high");
    chk(16'hFFCC, 16'h0, S_RAM, 16'h01CC, 8'h00, 1'b1, 1'b0, "R8 irq table low");
    chk(16'hFFFD, 16'h0, S_RAM, 16'h01FD, 8'h00, 1'b1, 1'b0, "R8 irq table high");
    chk(16'hFFCB, 16'h0, S_ROM, 16'hFFCB, 8'h00, 1'b1, 1'b0, "R8 gap below irq table");
    chk(16'hFFC0, 16'h0, S_ROM, 16'hFFC0, 8'h00, 1'b1, 1'b0, "R8 gap above call table");
    chk(16'hFFFE, 16'h0, S_VEC, 16'hFFFE, 8'h00, 1'b1, 1'b0, "R10 reset vector low");
    chk(16'hFFFF, 16'h0, S_VEC, 16'hFFFF, 8'h00, 1'b1, 1'b0, "R10 reset vector high");
    // R5 flag pulse
    wr(KEY, 8'h71);
    chk(16'h0040, 16'h0, S_RAM, 16'h0040, 8'h00, 1'b1, 1'b1, "R5 pulse high after write");
    chk(16'h0040, 16'h0, S_RAM, 16'h0040, 8'h00, 1'b1, 1'b0, "R5 pulse one cycle");
    // R9 vector remap without map
    wr(CTRL, 8'h04);
    chk(16'h0040, CTRL, S_RAM, 16'h0040, 8'h04, 1'b1, 1'b0, "R2 restage keeps old commit");
    wr(KEY, 8'hD4);
    chk(16'h0040, 16'h0, S_LOW, 16'h0040, 8'h00, 1'b1, 1'b0, "R3 map cleared by key");
    chk(16'hFFA0, 16'h0, S_VEC, 16'hFFA0, 8'h00, 1'b1, 1'b0, "R9 call table not remapped");
    chk(16'hFFCC, 16'h0, S_VEC, 16'hFFCC, 8'h00, 1'b1, 1'b0, "R9 irq table not remapped");
    // R11 boot mode
    bootMode = 1'b1;
    chk(16'h0040, 16'h0, S_RAM, 16'h0040, 8'h00, 1'b1, 1'b0, "R11 boot forces window low");
    chk(16'h083F, 16'h0, S_RAM, 16'h083F, 8'h00, 1'b1, 1'b0, "R11 boot forces window top");
    chk(16'h0840, 16'h0, S_ROM, 16'h0840, 8'h00, 1'b1, 1'b0, "R11 boot outside window");
    chk(16'hFFA0, 16'h0, S_VEC, 16'hFFA0, 8'h00, 1'b1, 1'b0, "R11 boot leaves vectors");
    bootMode = 1'b0;
    // R4 clear reset-disable
    wr(CTRL, 8'h00);
    wr(KEY, 8'hB2);
    chk(16'h2000, CTRL, S_ROM, 16'h2000, 8'h00, 1'b0, 1'b0, "R4 rstDisable cleared, R12 main ROM");
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule